// File: doc/BRIEF.md
# Mains-Locked Waveform Table Player

This block plays back one period of a stored test waveform, one entry per tick of a frequency-multiplied clock. A 10-bit address counter steps through a 1024-entry table of 8-bit unsigned amplitudes. Each tick produces one sample on a valid/ready output stream, and that stream drives a digital-to-analog converter. The table holds a triangle carrier that a square envelope switches between full and reduced depth, centred on mid-scale. It is built at elaboration from a function, so no memory file is needed.

Playback must stay locked to the mains phase, so the counter does not run freely. The reference square wave is synchronised and then halved. A one-clock clear pulse is formed on each edge of the halved signal, and that pulse zeroes the address counter. Two status outputs are provided. The wrap flag marks the natural roll of the address from its last entry back to the first. The misalignment flag latches when a clear lands in the middle of a scan.

The output stream has a producer that is paced by the tick. `out_valid` rises one clock after a tick and stays high until `out_ready` accepts the sample. A tick that arrives while a sample is still unaccepted replaces it with the newer value, because the source cannot be stalled. The tick and the reference are plain control inputs, and the two flags are plain status outputs.

Top module: `wtp_player`

## Requirements
- R1: During and after reset, `out_valid`, `wrap` and `misalign` are 0, and the address counter is 0, so the first tick emits table entry 0 (value 128).
- R2: The cycle after a tick, `out_valid` is 1 and `out_sample` holds the table entry at the current address. The address then advances by one, so consecutive ticks read consecutive entries.
- R3: The entry at address a is computed as follows:
  - p = (4·a) mod 1024, k = p div 256 and r = (p mod 256) div 2.
  - The carrier c is r, 127−r, −r or r−127 for k = 0, 1, 2 or 3.
  - The entry is 128+c when a mod 512 < 256. Otherwise it is 128 + (6·c)/8, with the division truncated toward zero.
- R4: Back-pressure works as follows:
  - While `out_valid` is 1 and `out_ready` is 0, with no new tick, `out_valid` stays 1 and `out_sample` stays unchanged.
  - A new tick in that state replaces the sample with the newer one.
  - One cycle after a cycle with `out_valid` and `out_ready` both high and no tick, `out_valid` is 0.
- R5: A tick at address 1023 with no clear rolls the address to 0 and pulses `wrap` high for exactly one cycle, alongside the sample of entry 1023. `wrap` is 0 at all other times.
- R6: Each rising edge of `ref_in` toggles an internally halved reference. Each edge of the halved signal yields a one-cycle clear, so every rising edge of `ref_in` clears the address. The address reads 0 after the fourth rising clock edge following the edge at which `ref_in` is first seen high.
- R7: Clear has priority over a tick in the same cycle. The address becomes 0, and that tick still emits the sample at the address held before the clear.
- R8: A clear that arrives while the address is neither 0 nor 1023 sets `misalign`, which then stays 1 until reset. A clear at address 0 or 1023 leaves it unchanged.
- R9: A falling edge of `ref_in` produces no clear, and playback continues from the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse from the frequency multiplier, one per table step |
| ref_in | input | 1 | Mains reference square wave (asynchronous) |
| out_ready | input | 1 | Downstream accepts the sample |
| out_valid | output | 1 | Sample available |
| out_sample | output | 8 | Unsigned sample for the converter |
| wrap | output | 1 | One-cycle pulse on a counted roll from 1023 to 0 |
| misalign | output | 1 | Sticky flag: a clear landed mid-scan |

## Verification
On every cycle, the bound checker enforces several behaviours:
- A clear always leaves the address at zero, and the clear pulse is never two cycles wide.
- An uncleared tick advances the address by exactly one.
- A held, unaccepted sample stays stable.
- The misalignment flag never drops.
- A wrap pulse only coincides with a counted roll from 1023.

Other behaviours need the bench's scenarios. These are the actual table values, the four-cycle latency from a reference edge to the clear, and the absence of a clear on a falling reference edge. The same holds for which sample a tick emits when it collides with a clear, and for whether a clear at the scan boundary leaves the flag untouched.

// File: rtl/wtp_pkg.sv
package wtp_pkg;

  // Table entry generator: triangle carrier, square envelope, mid-scale centre.
  function automatic int wave_at(input int a, input int depth, input int car_cyc,
                                 input int env_cyc, input int low_num, input int data_w);
    int quarter;
    int ph;
    int seg;
    int r;
    int c;
    int centre;
    quarter = depth / 4;
    centre  = 1 << (data_w - 1);
    ph      = (a * car_cyc) % depth;
    seg     = ph / quarter;
    r       = ((ph % quarter) * centre) / quarter / 2 * 2 / 2;
    r       = ((ph % quarter) * (centre / 2)) / (quarter / 2);
    case (seg)
      0:       c = r;
      1:       c = (centre - 1) - r;
      2:       c = -r;
      default: c = r - (centre - 1);
    endcase
    if (((a * env_cyc) % depth) < depth / 2) begin
      return centre + c;
    end
    return centre + (c * low_num) / 8;
  endfunction

endpackage

// File: rtl/wtp_ref_sync.sv
module wtp_ref_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic clr_pulse
);
  logic sync1_q, sync2_q, ref_d_q;
  logic half_q, half_d_q;
  logic ref_rise;

  assign ref_rise = sync2_q & ~ref_d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q  <= 1'b0;
      sync2_q  <= 1'b0;
      ref_d_q  <= 1'b0;
      half_q   <= 1'b0;
      half_d_q <= 1'b0;
    end else begin
      sync1_q  <= ref_in;
      sync2_q  <= sync1_q;
      ref_d_q  <= sync2_q;
      if (ref_rise) half_q <= ~half_q;
      half_d_q <= half_q;
    end
  end

  // Rising and falling edges of the halved reference, OR-combined.
  logic half_rise, half_fall;
  assign half_rise = half_q & ~half_d_q;
  assign half_fall = ~half_q & half_d_q;
  assign clr_pulse = half_rise | half_fall;
endmodule

// File: rtl/wtp_addr_ctr.sv
module wtp_addr_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  output logic [ADDR_W-1:0] addr,
  output logic              roll,
  output logic              misalign
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q;
  logic              mis_q;
  logic              at_edge;

  assign at_edge = (addr_q == '0) || (addr_q == LAST);
  assign roll    = tick && !clr && (addr_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      mis_q  <= 1'b0;
    end else begin
      if (clr) begin
        addr_q <= '0;
        if (!at_edge) mis_q <= 1'b1;
      end else if (tick) begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign addr     = addr_q;
  assign misalign = mis_q;
endmodule

// File: rtl/wtp_table.sv
module wtp_table #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int CARRIER_CYC = 4,
  parameter int ENV_CYC     = 2,
  parameter int ENV_LOW_NUM = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  import wtp_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign tbl[i] = DATA_W'(wave_at(i, DEPTH, CARRIER_CYC, ENV_CYC, ENV_LOW_NUM, DATA_W));
  end

  assign data = tbl[addr];
endmodule

// File: rtl/wtp_player.sv
module wtp_player #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int CARRIER_CYC = 4,
  parameter int ENV_CYC     = 2,
  parameter int ENV_LOW_NUM = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ref_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample,
  output logic              wrap,
  output logic              misalign
);
  logic              clr_pulse;
  logic [ADDR_W-1:0] addr_q;
  logic              roll;
  logic [DATA_W-1:0] rd_data;

  wtp_ref_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .clr_pulse(clr_pulse)
  );

  wtp_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_pulse),
    .addr(addr_q), .roll(roll), .misalign(misalign)
  );

  wtp_table #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CARRIER_CYC(CARRIER_CYC),
    .ENV_CYC(ENV_CYC), .ENV_LOW_NUM(ENV_LOW_NUM)
  ) u_tbl (
    .addr(addr_q), .data(rd_data)
  );

  logic [DATA_W-1:0] sample_q;
  logic              valid_q;
  logic              wrap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
      wrap_q   <= 1'b0;
    end else begin
      wrap_q <= roll;
      if (tick) begin
        sample_q <= rd_data;
        valid_q  <= 1'b1;
      end else if (valid_q && out_ready) begin
        valid_q  <= 1'b0;
      end
    end
  end

  assign out_sample = sample_q;
  assign out_valid  = valid_q;
  assign wrap       = wrap_q;
endmodule

// File: rtl/wtp_player_chk.sv
module wtp_player_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              clr,
  input logic [ADDR_W-1:0] addr,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_sample,
  input logic              wrap,
  input logic              misalign
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr == '0)); // R6

  AST_CLEAR_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !clr); // R6

  AST_TICK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R2

  AST_TICK_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> out_valid); // R2

  AST_HELD_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !tick) |=> (out_valid && $stable(out_sample))); // R4

  AST_WRAP_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap) |-> (addr == '0 && $past(addr) == LAST)); // R5

  AST_MISALIGN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> misalign); // R8
endmodule

bind wtp_player wtp_player_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_pulse), .addr(addr_q),
  .out_ready(out_ready), .out_valid(out_valid), .out_sample(out_sample),
  .wrap(wrap), .misalign(misalign)
);

// File: tb/wtp_player_tb.sv
module wtp_player_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ref_in = 1'b0;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [7:0] out_sample;
  logic       wrap;
  logic       misalign;

  int n_chk = 0;
  int n_bad = 0;
  int m_addr = 0;
  int last_exp = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wtp_player dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ref_in(ref_in), .out_ready(out_ready),
    .out_valid(out_valid), .out_sample(out_sample), .wrap(wrap), .misalign(misalign)
  );

  // Independent model of the table formula (R3).
  function automatic int mdl(input int a);
    int ph;
    int seg;
    int r;
    int c;
    ph  = (a * 4) % 1024;
    seg = ph / 256;
    r   = (ph % 256) / 2;
    if (seg == 0)      c = r;
    else if (seg == 1) c = 127 - r;
    else if (seg == 2) c = -r;
    else               c = r - 127;
    if ((a % 512) < 256) return 128 + c;
    return 128 + (c * 6) / 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One tick; returns at the negedge after the output register updated.
  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    last_exp = mdl(m_addr);
    m_addr   = (m_addr + 1) % 1024;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ref_pulse_rise();
    @(negedge clk) ref_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  localparam int NSTEP = 6;
  localparam int STEP_VEC [NSTEP] = '{1, 3, 17, 100, 250, 400};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(wrap == 1'b0, "R1 wrap", wrap, 0);
    chk(misalign == 1'b0, "R1 misalign", misalign, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after release", out_valid, 0);

    // Vector walk: R2 / R3 over several address ranges
    for (int i = 0; i < NSTEP; i++) begin
      repeat (STEP_VEC[i]) do_tick();
      chk(out_valid == 1'b1, "R2 valid after tick", out_valid, 1);
      chk(out_sample == 8'(last_exp), "R3 table value", out_sample, last_exp);
      chk(wrap == 1'b0, "R5 no wrap mid-scan", wrap, 0);
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 valid drops when accepted", out_valid, 0);

    // R4: back-pressure hold and replacement
    out_ready = 1'b0;
    do_tick();
    begin
      int held;
      held = last_exp;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b1, "R4 valid held", out_valid, 1);
      chk(out_sample == 8'(held), "R4 sample held", out_sample, held);
    end
    do_tick();
    chk(out_sample == 8'(last_exp), "R4 newer tick replaces", out_sample, last_exp);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 valid drops after accept", out_valid, 0);

    // R5: wrap at the end of the scan
    while (m_addr != 1023) do_tick();
    do_tick();
    chk(wrap == 1'b1, "R5 wrap pulse", wrap, 1);
    chk(out_sample == 8'(mdl(1023)), "R5 last entry", out_sample, mdl(1023));
    @(negedge clk);
    chk(wrap == 1'b0, "R5 wrap one cycle", wrap, 0);

    // R6 / R8: aligned clear at address 0 leaves misalign clear
    ref_pulse_rise();
    chk(misalign == 1'b0, "R8 aligned clear no flag", misalign, 0);
    m_addr = 0;
    do_tick();
    chk(out_sample == 8'(mdl(0)), "R6 after aligned clear", out_sample, mdl(0));

    // R9: falling reference edge does not clear
    @(negedge clk) ref_in = 1'b0;
    repeat (8) @(negedge clk);
    do_tick();
    chk(out_sample == 8'(mdl(1)), "R9 no clear on fall", out_sample, mdl(1));

    // R6 / R8: mid-scan clear sets the sticky flag
    repeat (3) do_tick();
    ref_pulse_rise();
    m_addr = 0;
    chk(misalign == 1'b1, "R8 mid-scan flag", misalign, 1);
    do_tick();
    chk(out_sample == 8'(mdl(0)), "R6 clear restarts scan", out_sample, mdl(0));
    @(negedge clk) ref_in = 1'b0;
    repeat (8) @(negedge clk);

    // R7: clear and tick in the same cycle
    repeat (10) do_tick();
    @(negedge clk) ref_in = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    last_exp = mdl(m_addr);
    @(negedge clk) tick = 1'b0;
    m_addr = 0;
    chk(out_sample == 8'(last_exp), "R7 pre-clear sample", out_sample, last_exp);
    chk(out_valid == 1'b1, "R7 valid on collision", out_valid, 1);
    do_tick();
    chk(out_sample == 8'(mdl(0)), "R7 clear won", out_sample, mdl(0));
    chk(misalign == 1'b1, "R8 flag stays set", misalign, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule